// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Shifter

This block is a byte-wide, full-duplex synchronous serial port driven from a simple register bus. One transfer sends eight bits out on `sdo` and takes in eight bits from `sdi`. A single shift register holds the byte, so after the transfer the data register contains the received byte. The serial clock idles high. The outgoing bit changes on each falling edge, and the incoming bit is sampled on each rising edge. The shift clock is either made inside the block by dividing the system clock, or taken from the `sck_in` pin. In the second case every edge arriving on the pin moves the transfer on.

A transfer starts in one of two ways. In manual mode, software writes a go bit. In automatic mode, any read or write of the data register starts it. A controller state machine tracks the transfer. It has three states. `ST_IDLE` is halted. `ST_HIGH` is the clock-high phase, which waits for a falling edge. `ST_LOW` is the clock-low phase, which waits for a rising edge. The transitions are: start (`ST_IDLE` to `ST_HIGH`), fall (`ST_HIGH` to `ST_LOW`), rise (`ST_LOW` to `ST_HIGH`), final rise after the eighth sample (`ST_LOW` to `ST_IDLE`), and abort (`ST_HIGH` or `ST_LOW` to `ST_IDLE`).

Registers are selected by `addr`:

| `addr` | Register |
|---|---|
| 0 | Low control byte |
| 1 | High control byte |
| 2 | Data register |
| 3 | Reads 0 |

Top module: `sio_shifter`

## Requirements
- R1: After reset, the high control byte reads 8'h02 (only the stop bit set) and the low control byte reads 8'h00. In the same state `irq`, `sck_oe` and `sdo_oe` are 0, and `sck_out` and `sdo` are 1.
- R2: Low control bit 2 selects the bit order. When it is 0, bit 0 is sent and received first. When it is 1, bit 7 goes first.
- R3: Each transfer sends all 8 bits of the data register and receives 8 bits from `sdi` at the same time. After the transfer, a read at address 2 returns the received byte.
- R4: High control bits 7:5 set the internal rate. Codes 0 to 4 divide the system clock by 2, 4, 8, 16 and 32. Codes 5 and 6 also divide by 32. A transfer keeps busy set for 8×divisor clocks. `sck_out` is high whenever the port is idle.
- R5: Low control bit 3 selects automatic mode. When it is 1, any read or write of address 2 while idle starts a transfer, and the go bit is ignored.
- R6: In manual mode (low control bit 3 = 0), writing 1 to high bit 0 (go) starts a transfer, and a write to the data register does not. The go bit always reads 0. Busy (high bit 2) reads 1 and stop (high bit 1) reads 0 during the transfer.
- R7: When the eighth bit has been sampled, busy clears, stop sets, and the done flag (high bit 3) sets.
- R8: Writing 0 to high bit 3 clears the done flag. Writing 1 to it has no effect. `irq` is the done flag AND the interrupt enable (high bit 4).
- R9: Writing 1 to high bit 1 aborts a running transfer. Busy then reads 0, stop reads 1, and the done flag stays clear. If the halt bit and the go bit are written together, no transfer starts.
- R10: While busy is set, the following have no effect: writes to low control bit 3, writes to the data register, and accesses that would start a transfer.
- R11: Rate code 7 selects external clock mode. The block synchronises `sck_in`: its falling edges shift a bit out and its rising edges sample a bit in. Without edges the transfer does not progress.
- R12: `sdo_oe` equals low control bit 1. `sck_oe` equals low control bit 0 in internal mode and is 0 in external mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 low control, 1 high control, 2 data |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; on address 2 in automatic mode it starts a transfer |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| sck_in | input | 1 | External shift clock |
| sdi | input | 1 | Serial data input |
| sck_out | output | 1 | Internal shift clock, idles high |
| sck_oe | output | 1 | Output enable for the shift clock pin |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for the serial data pin |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the controller leaves `ST_LOW` or `ST_HIGH` one phase early or late. Then the busy time differs from 8×divisor clocks, and the bench sees this within one transfer. A bad bit index or shift direction corrupts the bit sequence seen on `sdo` at the rising edges of `sck_out`. It also corrupts the byte read back at address 2 right after busy falls. A stuck flag, stop or mode bit appears on the next control read, or on `irq`, in the cycle after the write or after the final rise.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } sio_state_e;

    localparam logic [1:0] ADDR_CTL_LO = 2'd0;
    localparam logic [1:0] ADDR_CTL_HI = 2'd1;
    localparam logic [1:0] ADDR_DATA   = 2'd2;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
    parameter int RATE_W   = 3,
    parameter int CNT_W    = 5,
    parameter int RATE_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic              sck_in,
    output logic              tick,
    output logic              ext_fall,
    output logic              ext_rise
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  half_m1;
    logic [RATE_W-1:0] rate_eff;
    logic [2:0]        sync_q;

    always_comb begin
        rate_eff = (rate > RATE_W'(RATE_MAX)) ? RATE_W'(RATE_MAX) : rate;
        half_m1  = (CNT_W'(1) << rate_eff) - CNT_W'(1);
    end

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], sck_in};
        end
    end

    assign ext_fall = sync_q[2] & ~sync_q[1];
    assign ext_rise = ~sync_q[2] & sync_q[1];
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic ext_mode,
    input  logic tick,
    input  logic ext_fall,
    input  logic ext_rise,
    output logic busy,
    output logic fall_evt,
    output logic rise_evt,
    output logic done,
    output logic sck_level
);
    localparam int IDX_W = $clog2(BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS - 1);

    sio_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             adv;

    always_comb begin
        if (ext_mode) begin
            adv = (state_q == ST_HIGH) ? ext_fall : ext_rise;
        end else begin
            adv = tick;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_HIGH;
            ST_HIGH: begin
                if (abort)    state_d = ST_IDLE;
                else if (adv) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (adv) begin
                    state_d = (idx_q == LAST_IDX) ? ST_IDLE : ST_HIGH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        sck_level = (state_q != ST_LOW);
        fall_evt  = (state_q == ST_HIGH) && adv && !abort;
        rise_evt  = (state_q == ST_LOW) && adv && !abort;
        done      = rise_evt && (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            idx_q <= '0;
        end else if (rise_evt) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/sio_shiftreg.sv
module sio_shiftreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             fall_evt,
    input  logic             rise_evt,
    input  logic             msb_first,
    input  logic             sdi,
    output logic [WIDTH-1:0] data,
    output logic             sdo
);
    logic [WIDTH-1:0] sr_q;
    logic             out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_data;
        end else if (rise_evt) begin
            if (msb_first) sr_q <= {sr_q[WIDTH-2:0], sdi};
            else           sr_q <= {sdi, sr_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (fall_evt) begin
            out_q <= msb_first ? sr_q[WIDTH-1] : sr_q[0];
        end
    end

    assign data = sr_q;
    assign sdo  = out_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RATE_W   = 3,
    parameter int RATE_MAX = 4,
    parameter int EXT_CODE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sck_in,
    input  logic              sdi,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq
);
    localparam int CNT_W = RATE_MAX + 1;

    logic [RATE_W-1:0] rate_q;
    logic              irq_en_q, flag_q, stop_q;
    logic              auto_q, msb_q, dout_en_q, cout_en_q;

    logic              busy, done, fall_evt, rise_evt, sck_level;
    logic              tick, ext_fall, ext_rise, ext_mode;
    logic              lo_wr, hi_wr, data_acc, halt_wr, go_wr;
    logic              start, abort, load;
    logic [DATA_W-1:0] shift_data;

    always_comb begin
        lo_wr    = wr_en && (addr == ADDR_CTL_LO);
        hi_wr    = wr_en && (addr == ADDR_CTL_HI);
        data_acc = (wr_en || rd_en) && (addr == ADDR_DATA);
        halt_wr  = hi_wr && wdata[1];
        go_wr    = hi_wr && wdata[0];
        ext_mode = (rate_q == RATE_W'(EXT_CODE));
        start    = !busy && !halt_wr && (auto_q ? data_acc : go_wr);
        abort    = busy && halt_wr;
        load     = !busy && wr_en && (addr == ADDR_DATA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q    <= 1'b0;
            msb_q     <= 1'b0;
            dout_en_q <= 1'b0;
            cout_en_q <= 1'b0;
        end else if (lo_wr) begin
            if (!busy) auto_q <= wdata[3];
            msb_q     <= wdata[2];
            dout_en_q <= wdata[1];
            cout_en_q <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= '0;
            irq_en_q <= 1'b0;
        end else if (hi_wr) begin
            rate_q   <= wdata[7:5];
            irq_en_q <= wdata[4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (hi_wr && !wdata[3]) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
        end else if (start) begin
            stop_q <= 1'b0;
        end else if (done || abort) begin
            stop_q <= 1'b1;
        end
    end

    sio_clkgen #(
        .RATE_W  (RATE_W),
        .CNT_W   (CNT_W),
        .RATE_MAX(RATE_MAX)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .rate    (rate_q),
        .sck_in  (sck_in),
        .tick    (tick),
        .ext_fall(ext_fall),
        .ext_rise(ext_rise)
    );

    sio_ctrl #(
        .BITS(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (abort),
        .ext_mode (ext_mode),
        .tick     (tick),
        .ext_fall (ext_fall),
        .ext_rise (ext_rise),
        .busy     (busy),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .done     (done),
        .sck_level(sck_level)
    );

    sio_shiftreg #(
        .WIDTH(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_data(wdata),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .msb_first(msb_q),
        .sdi      (sdi),
        .data     (shift_data),
        .sdo      (sdo)
    );

    always_comb begin
        unique case (addr)
            ADDR_CTL_LO: rdata = {4'b0000, auto_q, msb_q, dout_en_q, cout_en_q};
            ADDR_CTL_HI: rdata = {rate_q, irq_en_q, flag_q, busy, stop_q, 1'b0};
            ADDR_DATA:   rdata = shift_data;
            default:     rdata = '0;
        endcase
    end

    assign sck_out = sck_level;
    assign sck_oe  = cout_en_q && !ext_mode;
    assign sdo_oe  = dout_en_q;
    assign irq     = flag_q && irq_en_q;
endmodule

// File: rtl/sio_shifter_chk.sv
module sio_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic flag_q,
    input logic stop_q,
    input logic auto_q,
    input logic halt_wr,
    input logic sck_out,
    input logic sck_oe,
    input logic ext_mode
);
    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag_q); // R7

    AST_STOP_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stop_q); // R6

    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(done)); // R8

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_wr && busy) |=> (!busy && stop_q)); // R9

    AST_AUTO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(auto_q)); // R10

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out); // R4

    AST_EXT_NO_CLK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> !sck_oe); // R12
endmodule

bind sio_shifter sio_shifter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .flag_q  (flag_q),
    .stop_q  (stop_q),
    .auto_q  (auto_q),
    .halt_wr (halt_wr),
    .sck_out (sck_out),
    .sck_oe  (sck_oe),
    .ext_mode(ext_mode)
);

// File: tb/sio_shifter_tb.sv
module sio_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sck_in = 1'b1;
    logic       sdi;
    logic       sck_out, sck_oe, sdo, sdo_oe, irq;

    int n_cmp = 0, n_bad = 0;
    logic finished = 1'b0;

    logic       mon_en = 1'b0, ext_run = 1'b0;
    logic       sdi_int = 1'b0, sdi_ext = 1'b0;
    logic [7:0] rx_cur = 8'h00, cap = 8'h00, cap_ext = 8'h00;
    logic       msb_cur = 1'b0;
    int         idx = 0;

    assign sdi = ext_run ? sdi_ext : sdi_int;

    always #2 clk = ~clk;

    sio_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .sck_in(sck_in), .sdi(sdi),
        .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
    );

    // Serial partner model for internal clock mode
    always @(negedge sck_out) begin
        if (mon_en && !ext_run && idx < 8)
            sdi_int <= msb_cur ? rx_cur[7-idx] : rx_cur[idx];
    end
    always @(posedge sck_out) begin
        if (mon_en && !ext_run && idx < 8) begin
            cap[idx] = sdo;
            idx = idx + 1;
        end
    end

    // {rate[2:0], msb_first, tx[7:0], rx[7:0]}
    localparam logic [19:0] VEC [5] = '{
        {3'd0, 1'b0, 8'hA5, 8'h3C},
        {3'd1, 1'b1, 8'h96, 8'hC3},
        {3'd3, 1'b0, 8'h01, 8'h80},
        {3'd0, 1'b1, 8'h80, 8'h01},
        {3'd2, 1'b1, 8'hFF, 8'h00}
    };

    function automatic logic [7:0] seq_of(input logic [7:0] b, input logic m);
        logic [7:0] s;
        for (int k = 0; k < 8; k++) s[k] = m ? b[7-k] : b[k];
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        @(negedge clk);
        for (int t = 0; t < 4000; t++) begin
            peek(2'd1, v);
            if (!v[2]) break;
            @(negedge clk);
        end
    endtask

    task automatic arm(input logic [7:0] rx, input logic m);
        rx_cur = rx; msb_cur = m; idx = 0; cap = 8'h00;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // R1 reset state
        peek(2'd1, v); check("R1 hi ctrl", v, 8'h02);
        peek(2'd0, v); check("R1 lo ctrl", v, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 sck_oe", sck_oe, 0);
        check("R1 sdo_oe", sdo_oe, 0);
        check("R1 sck_out", sck_out, 1);
        check("R1 sdo", sdo, 1);

        // Table of transfers: R2, R3, R7
        for (int i = 0; i < 5; i++) begin
            logic [2:0] rt; logic m; logic [7:0] tx, rx;
            {rt, m, tx, rx} = VEC[i];
            bus_write(2'd0, {5'b0, m, 2'b11});
            bus_write(2'd2, tx);
            arm(rx, m);
            bus_write(2'd1, {rt, 1'b1, 4'b0001});
            wait_idle();
            check("R2 sent bit order", cap, seq_of(tx, m));
            peek(2'd2, v); check("R3 received byte", v, rx);
            peek(2'd1, v); check("R7 flag/stop/busy", v[3:1], 3'b101);
            check("R8 irq with enable", irq, 1);
            bus_write(2'd1, 8'h10);
            check("R8 flag cleared irq", irq, 0);
        end

        // R4 transfer duration per rate code
        for (int i = 0; i < 3; i++) begin
            logic [2:0] rt;
            int expc;
            rt   = (i == 0) ? 3'd0 : (i == 1) ? 3'd2 : 3'd5;
            expc = (i == 0) ? 16 : (i == 1) ? 64 : 256;
            arm(8'h00, 1'b0);
            bus_write(2'd1, {rt, 5'b00001});
            cnt = 0;
            for (int t = 0; t < 1000; t++) begin
                peek(2'd1, v);
                if (!v[2]) break;
                cnt++;
                @(negedge clk);
            end
            check("R4 busy clocks", cnt, expc);
            check("R4 sck idle high", sck_out, 1);
        end

        // R6 go bit behaviour, manual mode data write does not start
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'h5A);
        peek(2'd1, v); check("R6 data write no start", v[2], 0);
        arm(8'h00, 1'b0);
        bus_write(2'd1, 8'h81);
        peek(2'd1, v);
        check("R6 go reads 0", v[0], 0);
        check("R6 busy set stop clear", v[2:1], 2'b10);

        // R9 halt aborts
        repeat (10) @(negedge clk);
        bus_write(2'd1, 8'h02);
        peek(2'd1, v); check("R9 abort state", v, 8'h02);
        bus_write(2'd1, 8'h03);
        peek(2'd1, v); check("R9 halt with go", v, 8'h02);

        // R8 clear-only flag and irq gating
        arm(8'h00, 1'b0);
        bus_write(2'd1, 8'h01);
        wait_idle();
        peek(2'd1, v); check("R8 flag set", v[3], 1);
        check("R8 irq disabled", irq, 0);
        bus_write(2'd1, 8'h08);
        peek(2'd1, v); check("R8 write 1 keeps flag", v[3], 1);
        bus_write(2'd1, 8'h18);
        check("R8 irq enabled", irq, 1);
        bus_write(2'd1, 8'h10);
        peek(2'd1, v); check("R8 write 0 clears", v[3], 0);
        check("R8 irq after clear", irq, 0);

        // R5 / R10 automatic mode
        bus_write(2'd0, 8'h0B);
        arm(8'h66, 1'b0);
        bus_write(2'd2, 8'h3C);
        peek(2'd1, v); check("R5 write starts", v[2], 1);
        bus_write(2'd2, 8'h77);
        bus_write(2'd0, 8'h03);
        peek(2'd0, v); check("R10 mode write ignored", v, 8'h0B);
        wait_idle();
        check("R5 sent sequence", cap, seq_of(8'h3C, 1'b0));
        peek(2'd2, v); check("R10 data write ignored", v, 8'h66);
        arm(8'h21, 1'b0);
        bus_read(2'd2, v);
        peek(2'd1, v); check("R5 read starts", v[2], 1);
        wait_idle();
        check("R5 read-start sends held byte", cap, seq_of(8'h66, 1'b0));
        peek(2'd2, v); check("R3 received after read start", v, 8'h21);
        bus_write(2'd1, 8'h01);
        peek(2'd1, v); check("R5 go ignored in auto", v[2], 0);
        bus_write(2'd0, 8'h03);
        peek(2'd0, v); check("R10 mode write idle", v, 8'h03);

        // R12 output enables
        check("R12 sck_oe internal", sck_oe, 1);
        check("R12 sdo_oe on", sdo_oe, 1);
        bus_write(2'd0, 8'h01);
        check("R12 sdo_oe off", sdo_oe, 0);
        check("R12 sck_oe kept", sck_oe, 1);
        bus_write(2'd0, 8'h03);

        // R11 external clock mode
        bus_write(2'd2, 8'hC5);
        ext_run = 1'b1;
        bus_write(2'd1, 8'hE1);
        check("R12 sck_oe external", sck_oe, 0);
        repeat (20) @(negedge clk);
        peek(2'd1, v); check("R11 no edges no progress", v[2], 1);
        for (int k = 0; k < 8; k++) begin
            sck_in  = 1'b0;
            sdi_ext = 8'h9E >> k;
            repeat (6) @(negedge clk);
            cap_ext[k] = sdo;
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        peek(2'd1, v); check("R11 done after 8 edges", v[3:1], 3'b101);
        check("R11 sent sequence", cap_ext, seq_of(8'hC5, 1'b0));
        peek(2'd2, v); check("R11 received byte", v, 8'h9E);
        ext_run = 1'b0;
        bus_write(2'd1, 8'h00);

        finish_run();
    end
endmodule